// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Controller

This peripheral joins a keyboard and a character display to a simple processor load/store bus. Software sees four 32-bit word registers at fixed addresses: a control word and a data word for the receive direction, and a control word and a data word for the transmit direction. Each control word carries a ready flag and an interrupt-enable bit. The receive control word also carries a sticky overrun flag. Software can poll the ready flags, or it can set the enables and let a single interrupt request line call it.

The ready flags change as a side effect of ordinary bus traffic. A byte arriving from the keyboard is held in the receive data register and raises receive ready. Reading that register lowers the flag again. Writing a byte to the transmit data register while the transmitter is idle starts a one-cycle handoff to the display and lowers transmit ready. The flag returns once the display stops signalling busy. Each direction holds at most one character; nothing is queued.

Bus reads are combinational: read data is valid in the same cycle as the read strobe, and every side effect takes hold at the following clock edge.

Top module: `term_io_ctrl`

## Requirements
- R1: Registers sit at BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), with BASE defaulting to 0xFFFF0000. Only exact word addresses match. Read data is zero when the read strobe is low, when the address is unmapped, and for the transmit data register. A write to an unmapped address changes no state.
- R2: After reset the following hold: receive ready 0, overrun 0, both interrupt enables 0, transmit ready 1, display strobe 0, interrupt request 0, held receive byte 0x00.
- R3: Control word layout: bit 0 is the ready flag and bit 1 is the interrupt enable. On the receive control word only, bit 2 is the overrun flag. All other bits read as zero.
- R4: A keyboard byte strobe loads the byte at the next edge and sets receive ready. A receive data read returns the byte in bits 7:0, with bits 31:8 zero.
- R5: A read of receive data clears receive ready at the next edge. If a keyboard byte arrives in the same cycle as that read, the read returns the old byte, the new byte is loaded, ready stays 1 and no overrun is recorded.
- R6: A keyboard byte that arrives while receive ready is 1, with no receive data read in that cycle, replaces the held byte, leaves ready at 1 and sets the overrun flag. Overrun stays set until a receive control read clears it at the next edge. A new overrun in that same cycle keeps it set.
- R7: A write to a control word updates only its interrupt enable, from write data bit 1. Writes to the ready and overrun bits, and any write to receive data, are ignored.
- R8: A write to transmit data while transmit ready is 1 drives the display strobe high for exactly one cycle, starting at the next edge. The display byte during that cycle is write data bits 7:0. Transmit ready is 0 from that edge on.
- R9: After the strobe cycle, transmit ready returns to 1 at the first edge where the display busy input is 0.
- R10: A write to transmit data while transmit ready is 0 is dropped. It produces no strobe and leaves the display byte unchanged.
- R11: The interrupt request is high exactly when (receive enable and receive ready) or (transmit enable and transmit ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Keyboard byte |
| disp_valid | output | 1 | One-cycle strobe handing a byte to the display |
| disp_byte | output | 8 | Byte for the display |
| disp_busy | input | 1 | Display still consuming the previous byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets three cases:
- A keyboard byte that arrives in the same cycle as the receive data read. A design that misorders this would lose the new byte, drop ready, or flag a false overrun.
- An overrun followed by a control read. A flag that is not sticky, or that is never cleared, shows up on the next control read.
- Transmit writes issued while the display is still busy. A design that accepts them would emit a second strobe or change the display byte.

It also runs the display with zero and non-zero busy lengths. A ready flag that returns one edge early or late then mismatches the cycle-accurate model, as does an interrupt line that ignores an enable.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

  localparam int REG_COUNT = 4;
  localparam int REG_RXC   = 0;
  localparam int REG_RXD   = 1;
  localparam int REG_TXC   = 2;
  localparam int REG_TXD   = 3;

  // Transmit handshake: idle (ready), strobe cycle, waiting on display busy.
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_DRAIN = 2'd2
  } tx_state_e;

  // Byte offset of register slot idx from the block base.
  function automatic logic [3:0] slot_offset(input int idx);
    return 4'(idx * 4);
  endfunction

  // Request from one direction.
  function automatic logic dir_request(input logic ready, input logic enable);
    return ready & enable;
  endfunction

endpackage

// File: rtl/term_reg_decode.sv
module term_reg_decode
  import term_io_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [REG_COUNT-1:0] rd_sel,
  output logic [REG_COUNT-1:0] wr_sel
);

  logic [REG_COUNT-1:0] hit;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE_ADDR + ADDR_W'(slot_offset(i));
    assign hit[i]    = (addr == SLOT_ADDR);
    assign rd_sel[i] = hit[i] & rd;
    assign wr_sel[i] = hit[i] & wr;
  end

  // R1: at most one register answers an access
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel) && $onehot0(wr_sel));

endmodule

// File: rtl/term_rx_port.sv
module term_rx_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_byte,
  input  logic              data_rd,
  input  logic              ctrl_rd,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              rx_ie,
  output logic              rx_overrun,
  output logic              overrun_event
);

  // A byte lands on top of one software has not taken.
  assign overrun_event = key_valid & rx_ready & ~data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte    <= '0;
      rx_ready   <= 1'b0;
      rx_ie      <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (key_valid) begin
        rx_byte  <= key_byte;
        rx_ready <= 1'b1;
      end else if (data_rd) begin
        rx_ready <= 1'b0;
      end
      if (overrun_event)
        rx_overrun <= 1'b1;
      else if (ctrl_rd)
        rx_overrun <= 1'b0;
      if (ctrl_wr)
        rx_ie <= ie_wdata;
    end
  end

  assert_key_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> rx_ready && rx_byte == $past(key_byte));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_valid) |=> !rx_ready);

  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_event |=> rx_overrun);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !ctrl_rd) |=> rx_overrun);

  assert_ie_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(rx_ie));

endmodule

// File: rtl/term_tx_port.sv
module term_tx_port
  import term_io_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  input  logic              disp_busy,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  output logic              tx_ready,
  output logic              tx_ie,
  output logic              accept_event,
  output logic              drop_event
);

  tx_state_e state, state_nx;

  assign tx_ready     = (state == TX_IDLE);
  assign disp_valid   = (state == TX_SEND);
  assign accept_event = data_wr & tx_ready;
  assign drop_event   = data_wr & ~tx_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      TX_IDLE:  if (accept_event) state_nx = TX_SEND;
      TX_SEND:  state_nx = TX_DRAIN;
      TX_DRAIN: if (!disp_busy) state_nx = TX_IDLE;
      default:  state_nx = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      disp_byte <= '0;
      tx_ie     <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept_event)
        disp_byte <= wr_byte;
      if (ctrl_wr)
        tx_ie <= ie_wdata;
    end
  end

  assert_accept_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_event |=> disp_valid && !tx_ready && disp_byte == $past(wr_byte));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);

  assert_ready_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !disp_valid && !disp_busy) |=> tx_ready);

  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_event |=> !disp_valid && $stable(disp_byte));

endmodule

// File: rtl/term_io_ctrl.sv
module term_io_ctrl
  import term_io_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_byte,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  input  logic              disp_busy,
  output logic              irq
);

  localparam int IE_BIT  = 1;
  localparam int OVR_BIT = 2;

  logic [REG_COUNT-1:0] rd_sel, wr_sel;
  logic [CHAR_W-1:0]    rx_byte;
  logic                 rx_ready, rx_ie, rx_overrun, overrun_event;
  logic                 tx_ready, tx_ie, accept_event, drop_event;
  logic                 unused_events;

  assign unused_events = overrun_event ^ accept_event ^ drop_event;

  term_reg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  term_rx_port #(.CHAR_W(CHAR_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_valid     (kb_valid),
    .key_byte      (kb_byte),
    .data_rd       (rd_sel[REG_RXD]),
    .ctrl_rd       (rd_sel[REG_RXC]),
    .ctrl_wr       (wr_sel[REG_RXC]),
    .ie_wdata      (bus_wdata[IE_BIT]),
    .rx_byte       (rx_byte),
    .rx_ready      (rx_ready),
    .rx_ie         (rx_ie),
    .rx_overrun    (rx_overrun),
    .overrun_event (overrun_event)
  );

  term_tx_port #(.CHAR_W(CHAR_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_wr      (wr_sel[REG_TXD]),
    .wr_byte      (bus_wdata[CHAR_W-1:0]),
    .ctrl_wr      (wr_sel[REG_TXC]),
    .ie_wdata     (bus_wdata[IE_BIT]),
    .disp_busy    (disp_busy),
    .disp_valid   (disp_valid),
    .disp_byte    (disp_byte),
    .tx_ready     (tx_ready),
    .tx_ie        (tx_ie),
    .accept_event (accept_event),
    .drop_event   (drop_event)
  );

  // Read mux: each register contributes only when selected.
  always_comb begin
    bus_rdata = '0;
    if (rd_sel[REG_RXC]) begin
      bus_rdata[0]       = rx_ready;
      bus_rdata[IE_BIT]  = rx_ie;
      bus_rdata[OVR_BIT] = rx_overrun;
    end
    if (rd_sel[REG_RXD])
      bus_rdata[CHAR_W-1:0] = rx_byte;
    if (rd_sel[REG_TXC]) begin
      bus_rdata[0]      = tx_ready;
      bus_rdata[IE_BIT] = tx_ie;
    end
  end

  assign irq = dir_request(rx_ready, rx_ie) | dir_request(tx_ready, tx_ie);

  // R11: no request while both enables are off
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq);

  assert_irq_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && rx_ready) |-> irq);

  assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/term_io_ctrl_test.sv
module term_io_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFFFF0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_byte = '0;
  logic        disp_valid;
  logic [7:0]  disp_byte;
  logic        disp_busy = 1'b0;
  logic        irq;

  int compared = 0, mismatched = 0;
  int busy_len = 0, busy_left = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] m_rx_byte;
  bit m_rx_rdy, m_rx_ie, m_ovr, m_tx_ie;
  int m_tx_st;  // 0 ready, 1 strobing, 2 waiting for display
  logic [7:0] m_tx_byte;

  term_io_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_byte(kb_byte), .disp_valid(disp_valid),
    .disp_byte(disp_byte), .disp_busy(disp_busy), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata(input bit rd, input logic [31:0] a);
    logic [31:0] v = 32'h0;
    if (!rd) return v;
    if (a == A_RXC) v = {29'd0, m_ovr, m_rx_ie, m_rx_rdy};
    else if (a == A_RXD) v = {24'd0, m_rx_byte};
    else if (a == A_TXC) v = {30'd0, m_tx_ie, (m_tx_st == 0)};
    return v;
  endfunction

  task automatic model_reset();
    m_rx_byte = 8'h00; m_rx_rdy = 0; m_rx_ie = 0; m_ovr = 0;
    m_tx_ie = 0; m_tx_st = 0; m_tx_byte = 8'h00;
  endtask

  task automatic compare_outputs(input string req);
    bit exp_irq;
    exp_irq = (m_rx_ie && m_rx_rdy) || (m_tx_ie && m_tx_st == 0);
    check(req, "irq", {31'd0, irq}, {31'd0, exp_irq});
    check(req, "disp_valid", {31'd0, disp_valid}, {31'd0, (m_tx_st == 1)});
    if (m_tx_st == 1) check(req, "disp_byte", {24'd0, disp_byte}, {24'd0, m_tx_byte});
  endtask

  // One bus cycle; called just after a falling edge.
  task automatic cyc(input string req, input bit rd, input bit wr,
                     input logic [31:0] a, input logic [31:0] wd,
                     input bit kv, input logic [7:0] kb);
    bit rd_rxc, rd_rxd, wr_rxc, wr_txc, wr_txd, ovr_set;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    kb_valid = kv; kb_byte = kb;
    if (disp_valid) busy_left = busy_len;
    disp_busy = (busy_left > 0);
    #1;
    check(req, "rdata", bus_rdata, model_rdata(rd, a));
    @(posedge clk);
    rd_rxc = rd && a == A_RXC; rd_rxd = rd && a == A_RXD;
    wr_rxc = wr && a == A_RXC; wr_txc = wr && a == A_TXC; wr_txd = wr && a == A_TXD;
    ovr_set = kv && m_rx_rdy && !rd_rxd;
    if (kv) begin m_rx_byte = kb; m_rx_rdy = 1; end
    else if (rd_rxd) m_rx_rdy = 0;
    if (ovr_set) m_ovr = 1; else if (rd_rxc) m_ovr = 0;
    if (wr_rxc) m_rx_ie = wd[1];
    if (wr_txc) m_tx_ie = wd[1];
    case (m_tx_st)
      0: if (wr_txd) begin m_tx_st = 1; m_tx_byte = wd[7:0]; end
      1: m_tx_st = 2;
      default: if (!disp_busy) m_tx_st = 0;
    endcase
    if (busy_left > 0) busy_left--;
    @(negedge clk);
    compare_outputs(req);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 32'h0, 32'h0, 0, 8'h00);
  endtask

  task automatic rd_reg(input string req, input logic [31:0] a);
    cyc(req, 1, 0, a, 32'h0, 0, 8'h00);
  endtask

  task automatic wr_reg(input string req, input logic [31:0] a, input logic [31:0] d);
    cyc(req, 0, 1, a, d, 0, 8'h00);
  endtask

  task automatic key(input string req, input logic [7:0] b);
    cyc(req, 0, 0, 32'h0, 32'h0, 1, b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    compare_outputs("R2");
    rd_reg("R2", A_RXC);
    rd_reg("R2", A_TXC);
    rd_reg("R2", A_RXD);

    // R1: unmapped reads/writes, misaligned and neighbouring addresses
    rd_reg("R1", BASE + 32'h10);
    rd_reg("R1", BASE + 32'h1);
    rd_reg("R1", 32'h0000_0004);
    rd_reg("R1", A_TXD);
    wr_reg("R1", BASE + 32'h12, 32'hFFFF_FFFF);
    wr_reg("R1", BASE + 32'h9, 32'hFFFF_FFFF);
    rd_reg("R1", A_RXC);
    rd_reg("R1", A_TXC);

    // R4 / R5: receive path
    key("R4", 8'h41);
    rd_reg("R3", A_RXC);
    rd_reg("R4", A_RXD);
    rd_reg("R5", A_RXC);
    rd_reg("R4", A_RXD);

    // R6: overrun sets, stays, cleared by control read
    key("R6", 8'h10);
    key("R6", 8'h22);
    idle("R6", 2);
    rd_reg("R6", A_RXC);
    rd_reg("R6", A_RXC);
    rd_reg("R6", A_RXD);

    // R5: arrival in the same cycle as the data read
    key("R5", 8'h33);
    cyc("R5", 1, 0, A_RXD, 32'h0, 1, 8'h44);
    rd_reg("R5", A_RXC);
    rd_reg("R5", A_RXD);
    rd_reg("R5", A_RXC);

    // R6: overrun set in the same cycle as a control read keeps it
    key("R6", 8'h51);
    cyc("R6", 1, 0, A_RXC, 32'h0, 1, 8'h52);
    rd_reg("R6", A_RXC);
    rd_reg("R6", A_RXD);

    // R7: only the enable bit is writable
    wr_reg("R7", A_RXC, 32'hFFFF_FFFF);
    rd_reg("R7", A_RXC);
    wr_reg("R7", A_RXD, 32'h0000_0099);
    key("R11", 8'h60);
    wr_reg("R7", A_RXD, 32'h0000_00AA);
    rd_reg("R7", A_RXD);
    wr_reg("R7", A_RXC, 32'h0000_0001);
    key("R11", 8'h61);
    rd_reg("R7", A_RXC);
    rd_reg("R7", A_RXD);

    // R8 / R9 / R10: transmit with a slow display
    busy_len = 3;
    wr_reg("R8", A_TXD, 32'hDEAD_BE5A);
    wr_reg("R10", A_TXD, 32'h0000_0077);
    rd_reg("R8", A_TXC);
    wr_reg("R10", A_TXD, 32'h0000_0078);
    idle("R9", 4);
    rd_reg("R9", A_TXC);

    // R9: display with no busy time
    busy_len = 0;
    wr_reg("R8", A_TXD, 32'h0000_0031);
    idle("R9", 1);
    rd_reg("R9", A_TXC);
    wr_reg("R8", A_TXD, 32'h0000_0032);
    wr_reg("R10", A_TXD, 32'h0000_0033);
    idle("R9", 2);

    // R11: interrupt from the transmit side and from both
    wr_reg("R11", A_TXC, 32'h0000_0002);
    idle("R11", 1);
    busy_len = 2;
    wr_reg("R11", A_TXD, 32'h0000_0041);
    idle("R11", 4);
    wr_reg("R11", A_RXC, 32'h0000_0002);
    key("R11", 8'h7E);
    rd_reg("R11", A_RXD);
    wr_reg("R11", A_TXC, 32'h0000_0000);
    wr_reg("R11", A_RXC, 32'h0000_0000);
    idle("R11", 2);

    // R2: reset mid-operation returns to the idle state
    key("R2", 8'h5F);
    wr_reg("R2", A_TXD, 32'h0000_0012);
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    busy_left = 0;
    rst_n = 1'b1;
    compare_outputs("R2");
    rd_reg("R2", A_RXC);
    rd_reg("R2", A_RXD);
    rd_reg("R2", A_TXC);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule